// File: doc/BRIEF.md
# Buffered Period/Duty PWM Channel

This block produces one pulse-width-modulated output. A 24-bit counter steps up from 1 only on cycles where the prescale tick is high. Two active compare values shape each period. When the counter equals the period value, the output goes to its active level, the counter restarts at 1, and a sticky period flag is raised. When the counter equals the duty value, the output returns to its idle level. The idle level is the polarity bit.

Software never writes the active compare values directly. Each write lands in a shadow register. Both shadows are copied into the active pair on the clock of a period match, so a period already in progress keeps its length and duty.

A qualified disable input parks the output at the idle level on the next clock. Once the disable is released, the output stays parked until the next compare match or force strobe. Two force strobes stand in for a duty match and for a period match. They act on any clock, tick or not, and never raise the flag. Every pin is a plain level or strobe. The block has no streaming data path, so it has no valid/ready handshake and no back-pressure.

Top module: `pwm_shadow_chan`

## Requirements
- R1: Reset leaves the output at the idle level (pwm_o equal to pol_i) and the flag low. The counter restarts at 1. The active duty and period take the RST_DUTY and RST_PERIOD parameter values, and so do the shadows.
- R2: The counter advances by one only on clocks where tick_i is high. On a tick clock where the counter equals the active period, the counter reloads to 1 instead, so one period lasts exactly "period" ticks.
- R3: A period match (tick high and counter equal to the active period) drives pwm_o to the active level, the inverse of pol_i, from the next clock. The same match sets flag_o.
- R4: A duty match (tick high and counter equal to the active duty) without a simultaneous period match drives pwm_o to pol_i from the next clock. A duty value of 0 never matches.
- R5: When duty and period match on the same count, the period match wins. Any duty value greater than or equal to the period therefore holds pwm_o at the active level permanently.
- R6: duty_wr_i and per_wr_i load only the shadow registers. The shadows are copied into the active pair only on a period-match clock. A shadow written on that same clock takes effect at the following match.
- R7: While dis_en_i and dis_i are both high, pwm_o is at pol_i from the next clock. This overrides matches and force strobes. When dis_en_i is low, dis_i has no effect.
- R8: After the disable is released, pwm_o stays at pol_i until the next duty match, period match or force strobe, which then applies as normal.
- R9: force_a_i drives pwm_o to pol_i on the next clock. force_b_i drives pwm_o to the active level and reloads the counter to 1 on the next clock. If both strobes are high together, force_b_i wins. Both act regardless of tick_i, and neither sets flag_o.
- R10: flag_o stays high until a clock with flag_clr_i high clears it. If a period match falls on the same clock as a clear, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Prescale enable; the counter steps only when high |
| pol_i | input | 1 | Idle output level; the active level is its inverse |
| duty_wr_i | input | 1 | Write strobe for the duty shadow |
| duty_wdata_i | input | CNT_W | New duty value |
| per_wr_i | input | 1 | Write strobe for the period shadow |
| per_wdata_i | input | CNT_W | New period value |
| dis_en_i | input | 1 | Enables the disable input for this channel |
| dis_i | input | 1 | Output disable request |
| force_a_i | input | 1 | Force a duty-match outcome |
| force_b_i | input | 1 | Force a period-match outcome and restart the counter |
| flag_clr_i | input | 1 | Clears the period flag |
| pwm_o | output | 1 | PWM output |
| flag_o | output | 1 | Sticky period-match flag |

## Verification
The hardest case to reach from the pins is a coincidence of events. Examples are a force or disable edge landing on the same clock as a period match during sparse ticks, and a shadow write made exactly on a reload clock. The bench sweeps small periods (1 to 5) and duties (0 to 6) in both polarities. An LFSR drives tick gaps, disables, strobes and writes, with the strobes enabled one mode at a time. Because periods are short, these coincidences occur many times in each run. Each output is compared every cycle with an arithmetic model of the counter, shadow pair, flag and output level.

// File: rtl/pwm_chan_pkg.sv
`timescale 1ns/1ps
package pwm_chan_pkg;

  // Compare bank slot indices: which register the output stage treats as
  // the duty compare and which as the period compare.
  localparam int SLOTS     = 2;
  localparam int SLOT_DUTY = 0;
  localparam int SLOT_PER  = 1;

  // Output-level events, highest priority first in pick_event.
  typedef enum logic [1:0] {
    EV_NONE   = 2'd0,
    EV_DUTY   = 2'd1,
    EV_PERIOD = 2'd2,
    EV_PARK   = 2'd3
  } pwm_ev_e;

  function automatic pwm_ev_e pick_event(input logic park,
                                         input logic per_ev,
                                         input logic duty_ev);
    if (park)    return EV_PARK;
    if (per_ev)  return EV_PERIOD;
    if (duty_ev) return EV_DUTY;
    return EV_NONE;
  endfunction

endpackage

// File: rtl/pwm_timebase.sv
`timescale 1ns/1ps
module pwm_timebase #(
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          restart_i,
  input  logic [CW-1:0] duty_i,
  input  logic [CW-1:0] per_i,
  output logic [CW-1:0] cnt_o,
  output logic          duty_hit_o,
  output logic          per_hit_o
);

  localparam logic [CW-1:0] CNT_START = CW'(1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  // Compares are qualified by the tick so a stalled count never re-fires.
  assign duty_hit_o = tick_i & (cnt_q == duty_i);
  assign per_hit_o  = tick_i & (cnt_q == per_i);

  always_comb begin
    cnt_d = cnt_q;
    if (restart_i || per_hit_o) begin
      cnt_d = CNT_START;
    end else if (tick_i) begin
      cnt_d = cnt_q + CNT_START;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CNT_START;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/pwm_cmp_bank.sv
`timescale 1ns/1ps
module pwm_cmp_bank
  import pwm_chan_pkg::*;
#(
  parameter int            CW       = 24,
  parameter logic [CW-1:0] RST_DUTY = CW'(4),
  parameter logic [CW-1:0] RST_PER  = CW'(8)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [SLOTS-1:0]           wr_i,
  input  logic [SLOTS-1:0][CW-1:0]   wdata_i,
  input  logic                       load_i,
  output logic [SLOTS-1:0][CW-1:0]   act_o
);

  localparam logic [SLOTS-1:0][CW-1:0] RST_VAL = {RST_PER, RST_DUTY};

  generate
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      logic [CW-1:0] shadow_q;
      logic [CW-1:0] active_q;

      // The active copy takes the shadow as it stood before this edge.
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          shadow_q <= RST_VAL[s];
          active_q <= RST_VAL[s];
        end else begin
          if (wr_i[s]) begin
            shadow_q <= wdata_i[s];
          end
          if (load_i) begin
            active_q <= shadow_q;
          end
        end
      end

      assign act_o[s] = active_q;
    end
  endgenerate

endmodule

// File: rtl/pwm_flag.sv
`timescale 1ns/1ps
module pwm_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);

  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (set_i) begin
      flag_q <= 1'b1;
    end else if (clr_i) begin
      flag_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/pwm_out_stage.sv
`timescale 1ns/1ps
module pwm_out_stage
  import pwm_chan_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pol_i,
  input  logic park_i,
  input  logic per_ev_i,
  input  logic duty_ev_i,
  output logic pwm_o
);

  pwm_ev_e ev;
  logic    act_q;   // 1: active level (inverse of polarity), 0: idle level
  logic    act_d;

  assign ev = pick_event(park_i, per_ev_i, duty_ev_i);

  always_comb begin
    act_d = act_q;
    unique case (ev)
      EV_PARK:   act_d = 1'b0;
      EV_DUTY:   act_d = 1'b0;
      EV_PERIOD: act_d = 1'b1;
      default:   act_d = act_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
    end else begin
      act_q <= act_d;
    end
  end

  assign pwm_o = pol_i ^ act_q;

endmodule

// File: rtl/pwm_shadow_chan.sv
`timescale 1ns/1ps
module pwm_shadow_chan
  import pwm_chan_pkg::*;
#(
  parameter int               CNT_W      = 24,
  parameter logic [CNT_W-1:0] RST_DUTY   = CNT_W'(4),
  parameter logic [CNT_W-1:0] RST_PERIOD = CNT_W'(8)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             pol_i,
  input  logic             duty_wr_i,
  input  logic [CNT_W-1:0] duty_wdata_i,
  input  logic             per_wr_i,
  input  logic [CNT_W-1:0] per_wdata_i,
  input  logic             dis_en_i,
  input  logic             dis_i,
  input  logic             force_a_i,
  input  logic             force_b_i,
  input  logic             flag_clr_i,
  output logic             pwm_o,
  output logic             flag_o
);

  logic [SLOTS-1:0]            bank_wr;
  logic [SLOTS-1:0][CNT_W-1:0] bank_wdata;
  logic [SLOTS-1:0][CNT_W-1:0] bank_act;
  logic [CNT_W-1:0]            duty_act;
  logic [CNT_W-1:0]            per_act;
  logic [CNT_W-1:0]            cnt_q;
  logic                        duty_hit;
  logic                        per_hit;
  logic                        park;

  assign bank_wr[SLOT_DUTY]    = duty_wr_i;
  assign bank_wr[SLOT_PER]     = per_wr_i;
  assign bank_wdata[SLOT_DUTY] = duty_wdata_i;
  assign bank_wdata[SLOT_PER]  = per_wdata_i;
  assign duty_act              = bank_act[SLOT_DUTY];
  assign per_act               = bank_act[SLOT_PER];
  assign park                  = dis_en_i & dis_i;

  pwm_timebase #(
    .CW (CNT_W)
  ) u_timebase (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick_i),
    .restart_i  (force_b_i),
    .duty_i     (duty_act),
    .per_i      (per_act),
    .cnt_o      (cnt_q),
    .duty_hit_o (duty_hit),
    .per_hit_o  (per_hit)
  );

  pwm_cmp_bank #(
    .CW       (CNT_W),
    .RST_DUTY (RST_DUTY),
    .RST_PER  (RST_PERIOD)
  ) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (bank_wr),
    .wdata_i (bank_wdata),
    .load_i  (per_hit),
    .act_o   (bank_act)
  );

  pwm_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (per_hit),
    .clr_i  (flag_clr_i),
    .flag_o (flag_o)
  );

  pwm_out_stage u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .pol_i     (pol_i),
    .park_i    (park),
    .per_ev_i  (per_hit | force_b_i),
    .duty_ev_i (duty_hit | force_a_i),
    .pwm_o     (pwm_o)
  );

endmodule

// File: rtl/pwm_shadow_chan_chk.sv
`timescale 1ns/1ps
module pwm_shadow_chan_chk #(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_i,
  input logic             pol_i,
  input logic             dis_en_i,
  input logic             dis_i,
  input logic             force_a_i,
  input logic             force_b_i,
  input logic             flag_clr_i,
  input logic             pwm_o,
  input logic             flag_o,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] per_act
);

  logic per_match;
  logic parked;
  assign per_match = tick_i && (cnt_q == per_act);
  assign parked    = dis_en_i && dis_i;

  // R2: no tick and no restart leaves the count alone
  assert_cnt_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !force_b_i) |=> $stable(cnt_q));

  // R2: a period match restarts the count at one
  assert_reload_R2: assert property (@(posedge clk) disable iff (!rst_n)
    per_match |=> (cnt_q == CNT_W'(1)));

  // R3: a period match raises the flag
  assert_flag_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    per_match |=> flag_o);

  // R3: an unparked period match gives the active level
  assert_active_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (per_match && !parked && $stable(pol_i)) |=> (pwm_o != pol_i));

  // R6: the active period changes only on a period match
  assert_period_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !per_match |=> $stable(per_act));

  // R7: an enabled disable parks the output at the idle level
  assert_park_R7: assert property (@(posedge clk) disable iff (!rst_n)
    parked |=> (pwm_o == pol_i));

  // R9: force_b gives the active level and restarts the count
  assert_force_b_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (force_b_i && !parked) |=> ((pwm_o != pol_i) && (cnt_q == CNT_W'(1))));

  // R9: force_a alone gives the idle level
  assert_force_a_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (force_a_i && !force_b_i && !per_match) |=> (pwm_o == pol_i));

  // R10: clear without a coinciding match drops the flag
  assert_flag_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr_i && !per_match) |=> !flag_o);

  // R10: without a clear the flag is held
  assert_flag_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !flag_clr_i) |=> flag_o);

endmodule

bind pwm_shadow_chan pwm_shadow_chan_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick_i     (tick_i),
  .pol_i      (pol_i),
  .dis_en_i   (dis_en_i),
  .dis_i      (dis_i),
  .force_a_i  (force_a_i),
  .force_b_i  (force_b_i),
  .flag_clr_i (flag_clr_i),
  .pwm_o      (pwm_o),
  .flag_o     (flag_o),
  .cnt_q      (cnt_q),
  .per_act    (per_act)
);

// File: tb/test_pwm_shadow_chan.sv
`timescale 1ns/1ps
module test_pwm_shadow_chan;

  localparam int          CW = 24;
  localparam logic [CW-1:0] RD = CW'(4);
  localparam logic [CW-1:0] RP = CW'(8);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick_i, pol_i, duty_wr_i, per_wr_i;
  logic [CW-1:0] duty_wdata_i, per_wdata_i;
  logic          dis_en_i, dis_i, force_a_i, force_b_i, flag_clr_i;
  logic          pwm_o, flag_o;

  always #10 clk = ~clk;   // 50 MHz

  pwm_shadow_chan #(.CNT_W(CW), .RST_DUTY(RD), .RST_PERIOD(RP)) i_pwm_shadow_chan (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .pol_i(pol_i),
    .duty_wr_i(duty_wr_i), .duty_wdata_i(duty_wdata_i),
    .per_wr_i(per_wr_i), .per_wdata_i(per_wdata_i),
    .dis_en_i(dis_en_i), .dis_i(dis_i),
    .force_a_i(force_a_i), .force_b_i(force_b_i), .flag_clr_i(flag_clr_i),
    .pwm_o(pwm_o), .flag_o(flag_o)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  // Arithmetic model of the requirements
  logic [CW-1:0] m_cnt, m_a1, m_b1, m_a2, m_b2;
  logic          m_act, m_flag;

  task automatic chk(input string tag, input logic act, input logic exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic idle_inputs();
    tick_i = 0; duty_wr_i = 0; per_wr_i = 0; duty_wdata_i = '0; per_wdata_i = '0;
    dis_en_i = 0; dis_i = 0; force_a_i = 0; force_b_i = 0; flag_clr_i = 0;
  endtask

  task automatic model_reset();
    m_cnt = CW'(1); m_a1 = RD; m_b1 = RP; m_a2 = RD; m_b2 = RP; m_act = 0; m_flag = 0;
  endtask

  // Advance the model across the coming edge using the driven inputs.
  task automatic model_step();
    logic per_hit, duty_hit, park;
    per_hit  = tick_i && (m_cnt == m_b1);
    duty_hit = tick_i && (m_cnt == m_a1);
    park     = dis_en_i && dis_i;
    if (per_hit) begin m_a1 = m_a2; m_b1 = m_b2; end
    if (duty_wr_i) m_a2 = duty_wdata_i;
    if (per_wr_i)  m_b2 = per_wdata_i;
    if (force_b_i || per_hit) m_cnt = CW'(1);
    else if (tick_i)          m_cnt = m_cnt + CW'(1);
    if (per_hit)         m_flag = 1;
    else if (flag_clr_i) m_flag = 0;
    if (park)                        m_act = 0;
    else if (per_hit || force_b_i)   m_act = 1;
    else if (duty_hit || force_a_i)  m_act = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    idle_inputs();
    repeat (2) @(negedge clk);
    rst_n = 1;
    model_reset();
    model_step();
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  initial begin
    idle_inputs();
    pol_i = 0;
    for (int pol = 0; pol < 2; pol++) begin
      for (int mode = 0; mode < 5; mode++) begin
        for (int p = 1; p <= 5; p++) begin
          for (int d = 0; d <= 6; d++) begin
            int idle_seen;
            string pwm_tag, flag_tag;
            idle_seen = 0;
            case (mode)
              0: pwm_tag = "R4";
              1: pwm_tag = "R6";
              2: pwm_tag = "R7";
              3: pwm_tag = "R9";
              default: pwm_tag = "R8";
            endcase
            flag_tag = (mode == 0) ? "R2" : (mode == 1) ? "R3" : "R10";
            pol_i = pol[0];
            do_reset();
            for (int cyc = 0; cyc < 40; cyc++) begin
              @(negedge clk);
              if (cyc == 0) begin
                chk("R1", pwm_o, pol_i, "reset output level");
                chk("R1", flag_o, 1'b0, "reset flag");
              end else begin
                chk(pwm_tag, pwm_o, pol_i ^ m_act, "pwm level");
                chk(flag_tag, flag_o, m_flag, "flag");
              end
              if (mode == 0 && d >= p && cyc >= 12 && pwm_o == pol_i) idle_seen++;
              lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
              idle_inputs();
              if (cyc == 0) begin
                duty_wr_i = 1; duty_wdata_i = CW'(d);
                per_wr_i  = 1; per_wdata_i  = CW'(p);
                tick_i    = 1;
              end else begin
                tick_i     = (mode == 0) ? 1'b1 : (lfsr[0] | lfsr[1]);
                dis_i      = (lfsr[5:3] == 3'd0);
                dis_en_i   = (mode == 2 || mode == 4);
                force_a_i  = (mode >= 3) && (lfsr[8:6] == 3'd0);
                force_b_i  = (mode >= 3) && (lfsr[11:9] == 3'd0);
                flag_clr_i = lfsr[12];
                if (mode >= 1 && lfsr[14:13] == 2'd0) begin
                  duty_wr_i = 1; duty_wdata_i = CW'(lfsr[7:5]);
                  per_wr_i  = lfsr[15]; per_wdata_i = CW'({1'b0, lfsr[2:1]} + 3'd1);
                end
              end
              model_step();
            end
            if (mode == 0 && d >= p)
              chk("R5", (idle_seen == 0), 1'b1, "period match wins, output held active");
          end
        end
      end
    end
    @(negedge clk);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired before the sweep ended");
      summary();
      $finish;
    end
  end

endmodule